// File: doc/BRIEF.md
# Pseudo-Random Rate Throttle

This block produces a single-bit, registered permit that gates a streaming interface. A source ANDs it into its valid, or a sink ANDs it into its ready. A 9-bit level picks the share of cycles on which the permit is high. Zero means the interface is frozen. 256 means it is never held back. Each value in between grants exactly that many cycles out of every 256.

The permitted cycles are scattered, not bunched. An 8-bit shift-register sequence steps on every clock. The permit is raised when the current sequence value is below the programmed level. The sequence is extended so that it also visits the all-zero word, which gives a period of 256 that holds every 8-bit value exactly once. Each instance starts from its own seed parameter, so two throttled interfaces in one design do not stall in step. A soft clear reloads the seed without a full reset. Dropping the enable holds the permit low while the sequence keeps running.

Top module: `pace_permit`

## Requirements
- R1: After the synchronous reset, the permit is low, and the sequence holds the effective seed until the first edge without reset.
- R2: When the level sampled at an edge is 0, the permit after that edge is low.
- R3: When the enable is high, the soft clear is low, and the level sampled at an edge is 256 or larger (values up to 511 saturate), the permit after that edge is high.
- R4: Hold the enable high, the soft clear low and the level constant at L ≤ 256. Then any 256 consecutive permit values contain exactly L ones.
- R5: The sequence word s is 8 bits. Its next value is {s[6:0], f}, where f = s[7]^s[5]^s[4]^s[3]^(s[6:0]==0). The permit after an edge is 1 when {1'b0,s} < level, using the word held before that edge.
- R6: The effective seed is the SEED parameter, or 8'h5A when SEED is 0. On the first edge after reset or soft clear is released, the permit is (seed < level).
- R7: While the soft clear is sampled high, the sequence is reloaded with the effective seed and the permit after that edge is low.
- R8: An enable sampled low forces the permit after that edge low, but the sequence still advances on that edge.
- R9: The permit is registered. It reflects the level and enable sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Permit enable; low forces the permit low |
| soft_rst | input | 1 | Soft clear: reloads the seed and holds the permit low |
| throttle | input | 9 | Permit level, 0 to 256 (higher values saturate) |
| permit | output | 1 | Registered permit flag |

## Verification
Several rules are checked by assertions on every cycle: the stopped and full-rate end points, the forced-low permit under a low enable or a soft clear, the seed reload, and the fact that the sequence never stalls on one word. The exact count of permits in a 256-cycle window, the cycle-by-cycle order of grants, and the zero-seed substitution cannot be seen by these local properties. The bench's window counts and its independent sequence model show them. The model also shows that the sequence keeps advancing while the enable is low, by matching the grant pattern after re-enabling.

// File: rtl/pace_pkg.sv
package pace_pkg;

  // Feedback tap mask (bit i set means stage i feeds back) for maximal sequences.
  function automatic logic [15:0] tap_mask(input int w);
    case (w)
      4:       return 16'h000C;
      5:       return 16'h0014;
      6:       return 16'h0030;
      7:       return 16'h0060;
      8:       return 16'h00B8;
      9:       return 16'h0110;
      10:      return 16'h0240;
      11:      return 16'h0500;
      12:      return 16'h0E08;
      16:      return 16'hD008;
      default: return 16'h00B8;
    endcase
  endfunction

  localparam logic [15:0] SEED_SUBST = 16'h005A;

  // A zero seed is swapped for a fixed non-zero start word.
  function automatic logic [15:0] fix_seed(input logic [15:0] s, input int w);
    logic [15:0] m;
    m = (w >= 16) ? 16'hFFFF : 16'((32'd1 << w) - 1);
    if ((s & m) == 16'h0) return SEED_SUBST & m;
    return s & m;
  endfunction

endpackage

// File: rtl/pace_lfsr.sv
module pace_lfsr #(
  parameter int             W        = 8,
  parameter logic [W-1:0]   START    = 8'h01,
  parameter logic [W-1:0]   TAPS     = 8'hB8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reload,
  output logic [W-1:0] word
);

  logic [W-1:0] st;
  logic         fb;
  logic         low_zero;

  // The extra term inserts the all-zero word, giving period 2**W.
  assign low_zero = (st[W-2:0] == '0);
  assign fb       = (^(st & TAPS)) ^ low_zero;

  always_ff @(posedge clk) begin
    if (rst || reload) st <= START;
    else               st <= {st[W-2:0], fb};
  end

  assign word = st;

  AST_RELOAD_SEED: assert property (@(posedge clk) disable iff (rst)
    reload |=> (st == START));                               // R7
  AST_SEQ_MOVES: assert property (@(posedge clk) disable iff (rst)
    !reload |=> (st != $past(st)));                           // R5

endmodule

// File: rtl/pace_cmp.sv
module pace_cmp #(
  parameter int LW = 8,
  parameter int TW = LW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          enable,
  input  logic [LW-1:0] level,
  input  logic [TW-1:0] thr,
  output logic          permit
);

  localparam logic [TW-1:0] FULL = TW'(1) << LW;

  logic [TW-1:0] level_x;
  logic          hit;
  logic          permit_q;

  assign level_x = TW'(level);
  assign hit     = (level_x < thr);

  always_ff @(posedge clk) begin
    if (rst || hold) permit_q <= 1'b0;
    else             permit_q <= enable && hit;
  end

  assign permit = permit_q;

  AST_ZERO_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (thr == '0) |=> !permit_q);                               // R2
  AST_FULL_RATE: assert property (@(posedge clk) disable iff (rst)
    (enable && !hold && thr >= FULL) |=> permit_q);           // R3
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    (!enable || hold) |=> !permit_q);                         // R8

endmodule

// File: rtl/pace_permit.sv
module pace_permit #(
  parameter int              LFSR_W = 8,
  parameter logic [LFSR_W-1:0] SEED = 8'h3C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              soft_rst,
  input  logic [LFSR_W:0]   throttle,
  output logic              permit
);
  import pace_pkg::*;

  localparam int               THR_W    = LFSR_W + 1;
  localparam logic [LFSR_W-1:0] SEED_EFF = LFSR_W'(fix_seed(16'(SEED), LFSR_W));
  localparam logic [LFSR_W-1:0] TAPS     = LFSR_W'(tap_mask(LFSR_W));

  logic [LFSR_W-1:0] seq_word;

  pace_lfsr #(
    .W     (LFSR_W),
    .START (SEED_EFF),
    .TAPS  (TAPS)
  ) u_seq (
    .clk    (clk),
    .rst    (rst),
    .reload (soft_rst),
    .word   (seq_word)
  );

  pace_cmp #(
    .LW (LFSR_W),
    .TW (THR_W)
  ) u_cmp (
    .clk    (clk),
    .rst    (rst),
    .hold   (soft_rst),
    .enable (enable),
    .level  (seq_word),
    .thr    (throttle),
    .permit (permit)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !permit);                                         // R1

endmodule

// File: tb/pace_permit_test.sv
`timescale 1ns/1ps
module pace_permit_test;

  localparam logic [7:0] SEED_A = 8'h3C;
  localparam logic [7:0] SEED_Z = 8'h5A; // substitute for a zero seed

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic       soft_rst = 1'b0;
  logic [8:0] throttle = 9'd0;
  logic       permit_a, permit_z;

  always #2.5 clk = ~clk;

  pace_permit #(.LFSR_W(8), .SEED(SEED_A)) uut (
    .clk(clk), .rst(rst), .enable(enable), .soft_rst(soft_rst),
    .throttle(throttle), .permit(permit_a));

  pace_permit #(.LFSR_W(8), .SEED(8'h00)) uut_zero (
    .clk(clk), .rst(rst), .enable(enable), .soft_rst(soft_rst),
    .throttle(throttle), .permit(permit_z));

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] ms_a = SEED_A;
  logic [7:0] ms_z = SEED_Z;
  logic ep_a = 1'b0;
  logic ep_z = 1'b0;

  function automatic logic [7:0] seq_next(input logic [7:0] s);
    logic f;
    f = s[7] ^ s[5] ^ s[4] ^ s[3] ^ (s[6:0] == 7'd0);
    return {s[6:0], f};
  endfunction

  function automatic logic grant(input logic [7:0] s, input logic [8:0] t, input logic en);
    return en && ({1'b0, s} < t);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // One clock: update the model from inputs sampled at the edge, compare at the falling edge.
  task automatic tick(input string req);
    @(posedge clk);
    if (rst || soft_rst) begin
      ep_a = 1'b0; ep_z = 1'b0;
      ms_a = SEED_A; ms_z = SEED_Z;
    end else begin
      ep_a = grant(ms_a, throttle, enable);
      ep_z = grant(ms_z, throttle, enable);
      ms_a = seq_next(ms_a);
      ms_z = seq_next(ms_z);
    end
    @(negedge clk);
    check(req, 32'(permit_a), 32'(ep_a));
    check(req, 32'(permit_z), 32'(ep_z));
  endtask

  // R4: exact number of permits in 256 cycles at a constant level.
  task automatic window(input logic [8:0] t, input string req);
    int cnt;
    throttle = t;
    enable   = 1'b1;
    soft_rst = 1'b0;
    cnt = 0;
    for (int i = 0; i < 256; i++) begin
      tick(req);
      cnt += int'(permit_a);
    end
    check("R4", 32'(cnt), (t > 9'd256) ? 32'd256 : 32'(t));
  endtask

  initial begin
    #(200000 * 5.0);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: reset holds permit low
    enable = 1'b1; throttle = 9'd256;
    repeat (3) tick("R1");
    check("R1", 32'(permit_a), 32'd0);

    // R6: first permit after release uses the seed (0x3C < 0x3D, 0x5A not)
    rst = 1'b0; throttle = 9'h03D;
    tick("R6");
    check("R6", 32'(permit_a), 32'd1);
    check("R6", 32'(permit_z), 32'd0);
    repeat (20) tick("R5");

    // R9: a level change shows on the next permit
    throttle = 9'd0;   tick("R9"); check("R9", 32'(permit_a), 32'd0);
    throttle = 9'd256; tick("R9"); check("R9", 32'(permit_a), 32'd1);

    window(9'd0,   "R2");
    window(9'd1,   "R5");
    window(9'd128, "R5");
    window(9'd255, "R5");
    window(9'd256, "R3");
    window(9'd300, "R3");

    // R8: enable low blocks the permit while the sequence runs on
    throttle = 9'd256; enable = 1'b0;
    repeat (37) tick("R8");
    check("R8", 32'(permit_a), 32'd0);
    throttle = 9'd100; enable = 1'b1;
    repeat (40) tick("R8");

    // R7: soft clear holds permit low and reloads the seed
    soft_rst = 1'b1; throttle = 9'd256;
    repeat (5) tick("R7");
    check("R7", 32'(permit_a), 32'd0);
    soft_rst = 1'b0; throttle = 9'h03D;
    tick("R6");
    check("R6", 32'(permit_a), 32'd1);
    check("R6", 32'(permit_z), 32'd0);

    // Random levels, with random enable and soft-clear traffic in between
    void'($urandom(32'd20240611));
    for (int w = 0; w < 12; w++) begin
      window(9'($urandom % 320), "R4");
      for (int c = 0; c < 60; c++) begin
        throttle = 9'($urandom % 512);
        enable   = ($urandom % 4) != 0;
        soft_rst = ($urandom % 16) == 0;
        tick("R5");
      end
      soft_rst = 1'b0;
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule